// File: doc/BRIEF.md
# Frame-Gated System Reset Sequencer

This block owns the system reset of a serially loaded display driver. Two causes put the chip into reset. One is a supply-low flag from the analog voltage detector. The other is an active-low external reset pin. Both are asynchronous and pass through two-flop synchronizers before they are used. While reset is held, the block keeps the display off and stops key scanning. It clears the key data it passes on and parks the shared segment/port pins in a safe state.

Reset does not clear after a fixed delay. It clears only once every serial frame that the active duty mode needs has arrived. Four frames are needed in quarter-duty mode and three in third-duty mode. The block records each frame on the falling edge of chip-enable, using a frame-index input. After a supply-low reset, it releases on the chip-enable fall that completes the set. After a pin reset, it releases when the pin returns high, but only once the set is complete. The serial shift logic and the control register are never reset here, so display data can still be loaded during reset.

Top module: `dsp_rst_seq`

## Requirements
- R1: While the synchronized supply-low input is high, the block enters reset and stays there; `sys_rst_o` is high no later than the third clock edge after `supply_low_i` rises. Each cycle in which it is high clears the received-frame set.
- R2: A low level on `ext_rst_n_i` puts the block in reset no later than the third clock edge after the pin falls.
- R3: With `duty_third_i` = 0 (quarter duty), frames with index 0, 1, 2 and 3 must all be received before release. Repeating an index adds nothing.
- R4: With `duty_third_i` = 1 (third duty), frames 0, 1 and 2 complete the set, and a frame with index 3 is ignored.
- R5: A frame is recorded at the first clock edge that samples `ce_i` low after sampling it high, using `frame_idx_i` at that edge. When this completes the set, both causes are inactive and no clear is pending, `sys_rst_o` falls at that same edge.
- R6: After a pin reset, frames loaded while the pin is still low are kept. Reset clears only after the pin returns high, within three clock edges of that rise.
- R7: While in reset, `disp_en_o` and `scan_en_o` are low and `key_o` is all zeros. Out of reset, they follow `disp_on_i`, `scan_on_i` and `key_raw_i`.
- R8: While in reset, shared pins 0 to 3 report segment function (`pin_port_sel_o` bit 0) and pin 4 reports port function (bit 1). All five pins have `pin_val_o` low and `pin_force_low_o` high. Out of reset, the pins pass `port_sel_i` and `port_val_i` through, with `pin_force_low_o` low.
- R9: A new reset cause during the release window clears the received-frame set, so frames loaded before it no longer count.
- R10: A change of `duty_third_i` while in reset clears the received-frame set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block flop reset, active low; the block starts in system reset |
| supply_low_i | input | 1 | Asynchronous flag from the voltage detector, 1 = supply at or below threshold |
| ext_rst_n_i | input | 1 | Asynchronous external reset pin, active low |
| ce_i | input | 1 | Serial chip-enable; a falling edge ends a frame |
| frame_idx_i | input | 2 | Index of the frame that is ending |
| duty_third_i | input | 1 | Duty mode from the control register, 1 = third duty, 0 = quarter duty |
| disp_on_i | input | 1 | Display-on request from the control register |
| scan_on_i | input | 1 | Key-scan request from the control register |
| key_raw_i | input | NKEY | Key buffer contents |
| port_sel_i | input | NSHR | Requested function per shared pin, 1 = port |
| port_val_i | input | NSHR | Requested port level per shared pin |
| sys_rst_o | output | 1 | System reset, active high |
| disp_en_o | output | 1 | Gated display enable |
| scan_en_o | output | 1 | Gated key-scan enable |
| key_o | output | NKEY | Gated key data |
| pin_port_sel_o | output | NSHR | Effective function per shared pin, 1 = port |
| pin_val_o | output | NSHR | Effective level per shared pin |
| pin_force_low_o | output | NSHR | 1 = pin held low by reset |

## Verification
The bench probes incomplete frame sets, such as three of four frames or a repeated index. A design that counts chip-enable falls instead of distinct indices would release early on these. In third-duty mode it sends index 3. A design that does not mask by duty would either accept it or wait for it forever. It re-asserts the supply-low flag partway through loading, and it changes the duty mode while in reset. A design that does not clear the set on these events releases on stale frames. It also loads a full set while the pin is still low. A design that ignores the pin level would release before the pin rises.

// File: rtl/dsprst_pkg.sv
package dsprst_pkg;
   typedef enum logic {
      DUTY_QUARTER = 1'b0,
      DUTY_THIRD   = 1'b1
   } duty_e;

   typedef enum logic {
      SEQ_RUN  = 1'b0,
      SEQ_HOLD = 1'b1
   } seq_e;

   localparam int MAX_FRAMES = 4;
   localparam int FIDX_W     = $clog2(MAX_FRAMES);

   function automatic logic [MAX_FRAMES-1:0] frames_needed(duty_e d);
      logic [MAX_FRAMES-1:0] m;
      m = '1;
      if (d == DUTY_THIRD) m[MAX_FRAMES-1] = 1'b0;
      return m;
   endfunction
endpackage

// File: rtl/dsprst_sync.sv
module dsprst_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("dsprst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsprst_frames.sv
module dsprst_frames
   import dsprst_pkg::*;
#(
   parameter int NFR   = MAX_FRAMES,
   parameter int IDX_W = FIDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_i,
   input  logic             clr_i,
   input  logic             ce_i,
   input  logic [IDX_W-1:0] idx_i,
   input  duty_e            duty_i,
   output logic [NFR-1:0]   vec_o,
   output logic             full_nxt_o,
   output logic             duty_chg_o
);
   if (NFR != MAX_FRAMES) begin : g_bad_nfr
      $error("dsprst_frames: NFR must match the package frame count");
   end
   if ((1 << IDX_W) < NFR) begin : g_bad_idx
      $error("dsprst_frames: IDX_W too narrow for NFR");
   end

   logic           ce_q;
   duty_e          duty_q;
   logic [NFR-1:0] vec_q, set_bits, vec_nxt, need;
   logic           ce_fall;

   assign ce_fall = ce_q & ~ce_i;
   assign need    = frames_needed(duty_i);

   for (genvar g = 0; g < NFR; g++) begin : g_slot
      assign set_bits[g] = ce_fall & capture_i & need[g] &
                           (idx_i == IDX_W'(g));
   end

   assign vec_nxt    = vec_q | set_bits;
   assign full_nxt_o = ((vec_nxt & need) == need);
   assign duty_chg_o = (duty_i != duty_q);
   assign vec_o      = vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b0;
         duty_q <= DUTY_QUARTER;
         vec_q  <= '0;
      end else begin
         ce_q   <= ce_i;
         duty_q <= duty_i;
         vec_q  <= clr_i ? '0 : vec_nxt;
      end
   end

   AST_SET_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((vec_q & $past(vec_q)) == $past(vec_q))) else $error("grow"); // R3
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (vec_q == '0)) else $error("clr"); // R9
endmodule

// File: rtl/dsprst_ctrl.sv
module dsprst_ctrl
   import dsprst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic low_s_i,
   input  logic pin_n_s_i,
   input  logic full_nxt_i,
   input  logic duty_chg_i,
   output logic in_rst_o,
   output logic clr_o,
   output logic capture_o
);
   seq_e state_q, state_d;
   logic pin_q, pin_fall, cause_now, release_ok;

   assign pin_fall  = pin_q & ~pin_n_s_i;
   assign cause_now = low_s_i | ~pin_n_s_i;

   always_comb begin
      clr_o      = 1'b0;
      release_ok = 1'b0;
      state_d    = state_q;
      unique case (state_q)
         SEQ_RUN: begin
            if (cause_now) begin
               clr_o   = 1'b1;
               state_d = SEQ_HOLD;
            end
         end
         SEQ_HOLD: begin
            clr_o      = low_s_i | pin_fall | duty_chg_i;
            release_ok = ~clr_o & full_nxt_i & pin_n_s_i & ~low_s_i;
            if (release_ok) state_d = SEQ_RUN;
         end
         default: state_d = SEQ_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_HOLD;
         pin_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         pin_q   <= pin_n_s_i;
      end
   end

   assign in_rst_o  = (state_q == SEQ_HOLD);
   assign capture_o = (state_q == SEQ_HOLD);

   AST_LOW_FORCES_RST: assert property (@(posedge clk) disable iff (!rst_n)
      low_s_i |=> (state_q == SEQ_HOLD)) else $error("low"); // R1
   AST_PIN_FORCES_RST: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_n_s_i |=> (state_q == SEQ_HOLD)) else $error("pin"); // R2
   AST_RELEASE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_rst_o) |-> ($past(full_nxt_i) && $past(pin_n_s_i) && !$past(low_s_i)))
      else $error("release"); // R5
endmodule

// File: rtl/dsprst_gate.sv
module dsprst_gate #(
   parameter int NKEY   = 8,
   parameter int NSHR   = 5,
   parameter int GP_IDX = 4
) (
   input  logic            in_rst_i,
   input  logic            disp_on_i,
   input  logic            scan_on_i,
   input  logic [NKEY-1:0] key_i,
   input  logic [NSHR-1:0] sel_i,
   input  logic [NSHR-1:0] val_i,
   output logic            disp_en_o,
   output logic            scan_en_o,
   output logic [NKEY-1:0] key_o,
   output logic [NSHR-1:0] sel_o,
   output logic [NSHR-1:0] val_o,
   output logic [NSHR-1:0] frc_o
);
   if (GP_IDX >= NSHR) begin : g_bad_gp
      $error("dsprst_gate: GP_IDX outside the shared pin range");
   end

   assign disp_en_o = disp_on_i & ~in_rst_i;
   assign scan_en_o = scan_on_i & ~in_rst_i;
   assign key_o     = in_rst_i ? '0 : key_i;

   for (genvar g = 0; g < NSHR; g++) begin : g_pin
      if (g == GP_IDX) begin : g_port
         assign sel_o[g] = in_rst_i | sel_i[g];
      end else begin : g_seg
         assign sel_o[g] = ~in_rst_i & sel_i[g];
      end
      assign val_o[g] = ~in_rst_i & val_i[g];
      assign frc_o[g] = in_rst_i;
   end
endmodule

// File: rtl/dsp_rst_seq.sv
module dsp_rst_seq
   import dsprst_pkg::*;
#(
   parameter int NKEY      = 8,
   parameter int NSHR      = 5,
   parameter int GP_IDX    = 4,
   parameter int SYNC_DPTH = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                supply_low_i,
   input  logic                ext_rst_n_i,
   input  logic                ce_i,
   input  logic [FIDX_W-1:0]   frame_idx_i,
   input  logic                duty_third_i,
   input  logic                disp_on_i,
   input  logic                scan_on_i,
   input  logic [NKEY-1:0]     key_raw_i,
   input  logic [NSHR-1:0]     port_sel_i,
   input  logic [NSHR-1:0]     port_val_i,
   output logic                sys_rst_o,
   output logic                disp_en_o,
   output logic                scan_en_o,
   output logic [NKEY-1:0]     key_o,
   output logic [NSHR-1:0]     pin_port_sel_o,
   output logic [NSHR-1:0]     pin_val_o,
   output logic [NSHR-1:0]     pin_force_low_o
);
   if (NKEY < 1) begin : g_bad_nkey
      $error("dsp_rst_seq: NKEY must be positive");
   end

   logic low_s, pin_n_s, full_nxt, duty_chg, in_rst, clr, capture;
   logic [MAX_FRAMES-1:0] seen_vec;

   dsprst_sync #(.STAGES(SYNC_DPTH), .RST_VAL(1'b1)) u_sync_low (
      .clk(clk), .rst_n(rst_n), .d_i(supply_low_i), .q_o(low_s));

   dsprst_sync #(.STAGES(SYNC_DPTH), .RST_VAL(1'b0)) u_sync_pin (
      .clk(clk), .rst_n(rst_n), .d_i(ext_rst_n_i), .q_o(pin_n_s));

   dsprst_frames #(.NFR(MAX_FRAMES), .IDX_W(FIDX_W)) u_frames (
      .clk(clk), .rst_n(rst_n), .capture_i(capture), .clr_i(clr),
      .ce_i(ce_i), .idx_i(frame_idx_i), .duty_i(duty_e'(duty_third_i)),
      .vec_o(seen_vec), .full_nxt_o(full_nxt), .duty_chg_o(duty_chg));

   dsprst_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .low_s_i(low_s), .pin_n_s_i(pin_n_s),
      .full_nxt_i(full_nxt), .duty_chg_i(duty_chg),
      .in_rst_o(in_rst), .clr_o(clr), .capture_o(capture));

   dsprst_gate #(.NKEY(NKEY), .NSHR(NSHR), .GP_IDX(GP_IDX)) u_gate (
      .in_rst_i(in_rst), .disp_on_i(disp_on_i), .scan_on_i(scan_on_i),
      .key_i(key_raw_i), .sel_i(port_sel_i), .val_i(port_val_i),
      .disp_en_o(disp_en_o), .scan_en_o(scan_en_o), .key_o(key_o),
      .sel_o(pin_port_sel_o), .val_o(pin_val_o), .frc_o(pin_force_low_o));

   assign sys_rst_o = in_rst;

   AST_ENTRY_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> (seen_vec == '0)) else $error("entry"); // R9
   AST_GATED_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |-> (!disp_en_o && !scan_en_o && key_o == '0)) else $error("gate"); // R7
   AST_PINS_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |-> (pin_val_o == '0 && pin_force_low_o == '1 &&
                     $countones(pin_port_sel_o) == 1 && pin_port_sel_o[GP_IDX]))
      else $error("pins"); // R8
   AST_THIRD_DUTY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_third_i && $stable(duty_third_i) && sys_rst_o && seen_vec[2:0] == 3'b111 &&
       !clr) |=> !sys_rst_o || !$past(pin_n_s) || $past(low_s)) else $error("third"); // R4
endmodule

// File: tb/dsp_rst_seq_tb_top.sv
module dsp_rst_seq_tb_top;
   localparam int NKEY = 8;
   localparam int NSHR = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_low = 1'b0, ext_rst_n = 1'b1, ce = 1'b0, duty_third = 1'b0;
   logic [1:0] fidx = 2'd0;
   logic disp_on = 1'b1, scan_on = 1'b1;
   logic [NKEY-1:0] key_raw = 8'hA5;
   logic [NSHR-1:0] psel = 5'b00101, pval = 5'b00111;
   logic sys_rst, disp_en, scan_en;
   logic [NKEY-1:0] key_o;
   logic [NSHR-1:0] sel_o, val_o, frc_o;

   int checks = 0, failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dsp_rst_seq dut_i (
      .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low), .ext_rst_n_i(ext_rst_n),
      .ce_i(ce), .frame_idx_i(fidx), .duty_third_i(duty_third),
      .disp_on_i(disp_on), .scan_on_i(scan_on), .key_raw_i(key_raw),
      .port_sel_i(psel), .port_val_i(pval), .sys_rst_o(sys_rst),
      .disp_en_o(disp_en), .scan_en_o(scan_en), .key_o(key_o),
      .pin_port_sel_o(sel_o), .pin_val_o(val_o), .pin_force_low_o(frc_o));

   typedef struct {
      logic [27:0] vec;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   function automatic logic [27:0] pack_obs();
      return {sys_rst, disp_en, scan_en, key_o, sel_o, val_o, frc_o};
   endfunction

   task automatic expect_state(bit in_rst, string tag);
      exp_t e;
      if (in_rst) e.vec = {1'b1, 1'b0, 1'b0, 8'h00, 5'b10000, 5'b00000, 5'b11111};
      else        e.vec = {1'b0, disp_on, scan_on, key_raw, psel, pval, 5'b00000};
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (pack_obs() !== e.vec) begin
               failures++;
               $display("FAIL %s actual=%h expected=%h", e.tag, pack_obs(), e.vec);
            end
         end
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(int idx);
      @(negedge clk);
      fidx = 2'(idx);
      ce = 1'b1;
      repeat (2) @(negedge clk);
      ce = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : driver
      idle(2);
      expect_state(1, "R7 R8 reset state");
      idle(1);
      rst_n = 1'b1;
      idle(5);
      expect_state(1, "R1 held after power-up");
      // R3: quarter duty needs all four distinct indices
      send_frame(0); send_frame(1); send_frame(2);
      expect_state(1, "R3 three of four frames");
      send_frame(2);
      expect_state(1, "R3 repeated index");
      send_frame(3);
      expect_state(0, "R5 R3 release on completing fall");
      idle(1);
      expect_state(0, "R7 R8 pass-through");
      // R1 then R4: third duty
      supply_low = 1'b1;
      idle(4);
      expect_state(1, "R1 supply-low entry");
      supply_low = 1'b0;
      duty_third = 1'b1;
      idle(4);
      send_frame(0); send_frame(1); send_frame(3);
      expect_state(1, "R4 index 3 ignored in third duty");
      send_frame(2);
      expect_state(0, "R4 R5 third-duty release");
      // R2 and R6: pin reset
      @(negedge clk);
      ext_rst_n = 1'b0;
      idle(4);
      expect_state(1, "R2 pin entry");
      send_frame(0); send_frame(1); send_frame(2);
      idle(2);
      expect_state(1, "R6 held while pin low");
      ext_rst_n = 1'b1;
      idle(4);
      expect_state(0, "R6 release on pin rise");
      // R9: re-assertion clears progress
      supply_low = 1'b1;
      idle(4);
      supply_low = 1'b0;
      idle(4);
      send_frame(0); send_frame(1);
      supply_low = 1'b1;
      idle(4);
      supply_low = 1'b0;
      idle(4);
      send_frame(2);
      expect_state(1, "R9 stale frames discarded");
      send_frame(0);
      expect_state(1, "R9 still incomplete");
      send_frame(1);
      expect_state(0, "R9 release after fresh set");
      // R10: duty change during reset clears progress
      supply_low = 1'b1;
      idle(4);
      supply_low = 1'b0;
      idle(4);
      send_frame(0); send_frame(1);
      duty_third = 1'b0;
      idle(3);
      send_frame(2); send_frame(3);
      expect_state(1, "R10 duty change cleared set");
      send_frame(0);
      expect_state(1, "R10 still missing frame 1");
      send_frame(1);
      expect_state(0, "R10 release after full quarter set");
      idle(3);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule